// File: doc/BRIEF.md
# Block-Transfer Mailbox Host Register Window

This block sits on the host side of a management mailbox that moves whole messages in blocks. The host sees three byte-wide registers at consecutive addresses. Offset 0 is a control/status register. Writing it issues one-shot commands: clearing the request length, rewinding the response reader, handing a request to the handler, acknowledging the attention flags and toggling the host-busy flag. Offset 1 is a data port. Writes append bytes to a request buffer. Reads drain bytes from a response buffer. Offset 2 belongs to a separate interrupt-mask block. This window returns 0xFF for it and for offset 3.

On the handler side the block offers a random-access read port into the request buffer, along with the running request length. A one-cycle strobe tells the handler that a request is ready. The handler returns its response as a valid/ready byte stream. `rsp_ready` is high only while the busy-to-host flag is set, so the handler cannot load a response unless a request is outstanding. A beat transfers on a cycle where `rsp_valid` and `rsp_ready` are both high. `rsp_valid`, `rsp_data` and `rsp_last` must stay stable until that happens. The beat with `rsp_last` high closes the response. The handler can also raise the system-management attention flag at any time through a plain pulse input.

Top module: `bt_mbox_regs`

## Requirements
- R1: After reset, the control register reads 0x00, the request length is 0 and the response buffer is empty.
- R2: A read of offset 0 returns the control byte, with busy-to-host at bit 7, host-busy at bit 6, system-management attention at bit 4 and response attention at bit 3. All other bits read 0. Reads of offsets 2 and 3 return 0xFF.
- R3: Writing offset 0 with bit 0 set clears the request length. Writing it with bit 1 set rewinds the response read pointer to the first byte, without changing the response length.
- R4: Writing offset 0 with bit 3 set clears response attention, and with bit 4 set clears system-management attention. Writing 0 in those bits leaves the flags unchanged.
- R5: Writing offset 0 with bit 6 set inverts host-busy. Writing 0 in bit 6 leaves it unchanged.
- R6: Writing offset 0 with bit 2 set sets busy-to-host. It also drives `req_go` high for exactly the one cycle after the write.
- R7: Each write to offset 1 stores its byte at index `req_len` if `req_len` is below DEPTH. `req_len` then increments whether or not the byte was stored, saturating at 2^LEN_W-1.
- R8: A read of offset 1 returns the next response byte and advances the pointer. When the last byte is read, both the pointer and the length return to 0. A read with no response byte pending returns 0xFF.
- R9: `rsp_ready` is high only while busy-to-host is set. Accepted beats are stored in order, and beats beyond DEPTH are dropped. The last beat sets the response length to the stored count, rewinds the pointer, clears busy-to-host and sets response attention.
- R10: A `sms_set` pulse sets system-management attention. If a set and a host clear of the same flag land in one cycle, the set wins. This holds for both attention flags.
- R11: `req_byte` combinationally shows the request byte stored at index `req_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 2 | Register offset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (data-port reads consume a byte) |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, combinational from `host_addr` |
| req_go | output | 1 | One-cycle request-ready strobe to the handler |
| req_len | output | LEN_W | Request byte count, saturating |
| req_idx | input | $clog2(DEPTH) | Request buffer read index |
| req_byte | output | 8 | Request byte at `req_idx` |
| rsp_valid | input | 1 | Response beat valid |
| rsp_ready | output | 1 | Response beat accepted when high |
| rsp_data | input | 8 | Response byte |
| rsp_last | input | 1 | Marks the final response beat |
| sms_set | input | 1 | Sets system-management attention |

## Verification
The bench builds the block with DEPTH = 8 and LEN_W = 5. This makes overruns past the request buffer reachable in a few writes, and the saturation of the request counter at 31 reachable after a few dozen. It sweeps every request length from 0 to 12 and every response length from 1 to 10. This covers exact fill, overrun, and the dropped-beat case on the response side, as well as pointer rewinds in the middle of a response.

// File: rtl/bt_mbox_pkg.sv
package bt_mbox_pkg;
  localparam logic [1:0] OFS_CTRL = 2'd0;
  localparam logic [1:0] OFS_DATA = 2'd1;

  localparam int unsigned CB_CLR_REQ  = 0;
  localparam int unsigned CB_CLR_RSP  = 1;
  localparam int unsigned CB_HOST_GO  = 2;
  localparam int unsigned CB_RSP_ATN  = 3;
  localparam int unsigned CB_SMS_ATN  = 4;
  localparam int unsigned CB_HOST_BSY = 6;
  localparam int unsigned CB_BMC_BSY  = 7;

  localparam logic [7:0] IDLE_BYTE = 8'hFF;
endpackage

// File: rtl/bt_mbox_ctrl.sv
module bt_mbox_ctrl
  import bt_mbox_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  input  logic       sms_set,
  input  logic       rsp_done,
  output logic [7:0] ctrl_byte,
  output logic       bmc_busy,
  output logic       req_go
);
  logic rsp_atn_q, sms_atn_q, host_bsy_q, bmc_bsy_q, go_q;
  logic [2:0] unused_bits;
  assign unused_bits = {wdata[5], wdata[CB_CLR_RSP], wdata[CB_CLR_REQ]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_atn_q  <= 1'b0;
      sms_atn_q  <= 1'b0;
      host_bsy_q <= 1'b0;
      bmc_bsy_q  <= 1'b0;
      go_q       <= 1'b0;
    end else begin
      go_q <= wr_en & wdata[CB_HOST_GO];
      if (wr_en && wdata[CB_HOST_BSY]) host_bsy_q <= ~host_bsy_q;
      if (wr_en && wdata[CB_HOST_GO]) bmc_bsy_q <= 1'b1;
      else if (rsp_done)              bmc_bsy_q <= 1'b0;
      if (rsp_done)                         rsp_atn_q <= 1'b1;
      else if (wr_en && wdata[CB_RSP_ATN])  rsp_atn_q <= 1'b0;
      if (sms_set)                          sms_atn_q <= 1'b1;
      else if (wr_en && wdata[CB_SMS_ATN])  sms_atn_q <= 1'b0;
    end
  end

  always_comb begin
    ctrl_byte              = 8'h00;
    ctrl_byte[CB_BMC_BSY]  = bmc_bsy_q;
    ctrl_byte[CB_HOST_BSY] = host_bsy_q;
    ctrl_byte[CB_SMS_ATN]  = sms_atn_q;
    ctrl_byte[CB_RSP_ATN]  = rsp_atn_q;
  end

  assign bmc_busy = bmc_bsy_q;
  assign req_go   = go_q;

  a_r5_hbusy_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata[CB_HOST_BSY]) |=> (host_bsy_q != $past(host_bsy_q)));
  a_r6_go_with_busy: assert property (@(posedge clk) disable iff (!rst_n)
    req_go |-> bmc_busy);
  a_r10_sms_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    sms_set |=> sms_atn_q);
  a_r4_rsp_atn_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata[CB_RSP_ATN] && !rsp_done) |=> !rsp_atn_q);
endmodule

// File: rtl/bt_mbox_req.sv
module bt_mbox_req #(
  parameter int DEPTH = 64,
  parameter int LEN_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [7:0]       din,
  input  logic             clr,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_byte,
  output logic [LEN_W-1:0] len
);
  localparam logic [LEN_W-1:0] DEPTH_L = LEN_W'(DEPTH);
  localparam logic [LEN_W-1:0] LEN_MAX = '1;

  logic [7:0] mem [DEPTH];
  logic [LEN_W-1:0] len_q;

  always_ff @(posedge clk) begin
    if (push && len_q < DEPTH_L) mem[len_q[IDX_W-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          len_q <= '0;
    else if (clr)                        len_q <= '0;
    else if (push && len_q != LEN_MAX)   len_q <= len_q + 1'b1;
  end

  assign rd_byte = mem[rd_idx];
  assign len     = len_q;

  a_r7_len_step: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !clr && len_q != LEN_MAX) |=> (len_q == $past(len_q) + 1'b1));
  a_r7_len_hold_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !clr && len_q == LEN_MAX) |=> (len_q == LEN_MAX));
endmodule

// File: rtl/bt_mbox_rsp.sv
module bt_mbox_rsp #(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CW = IDX_W + 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_last,
  input  logic       pop,
  input  logic       rewind,
  output logic [7:0] rd_byte,
  output logic       has_data,
  output logic       done
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [7:0]    mem [DEPTH];
  logic [CW-1:0] widx, len_q, ptr_q;
  logic          accept;

  assign accept = in_valid & in_ready;
  assign done   = accept & in_last;

  always_ff @(posedge clk) begin
    if (accept && widx < FULL) mem[widx[IDX_W-1:0]] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      widx  <= '0;
      len_q <= '0;
      ptr_q <= '0;
    end else if (done) begin
      widx  <= '0;
      len_q <= (widx < FULL) ? widx + 1'b1 : FULL;
      ptr_q <= '0;
    end else begin
      if (accept && widx < FULL) widx <= widx + 1'b1;
      if (rewind) ptr_q <= '0;
      else if (pop && ptr_q < len_q) begin
        if (ptr_q + 1'b1 == len_q) begin
          ptr_q <= '0;
          len_q <= '0;
        end else begin
          ptr_q <= ptr_q + 1'b1;
        end
      end
    end
  end

  assign has_data = (ptr_q < len_q);
  assign rd_byte  = has_data ? mem[ptr_q[IDX_W-1:0]] : 8'hFF;

  a_r8_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (len_q == '0) |-> (ptr_q == '0));
  a_r9_done_loads: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (len_q != '0 && ptr_q == '0 && len_q <= FULL));
endmodule

// File: rtl/bt_mbox_regs.sv
module bt_mbox_regs
  import bt_mbox_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int LEN_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       host_addr,
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic [7:0]       host_wdata,
  output logic [7:0]       host_rdata,
  output logic             req_go,
  output logic [LEN_W-1:0] req_len,
  input  logic [IDX_W-1:0] req_idx,
  output logic [7:0]       req_byte,
  input  logic             rsp_valid,
  output logic             rsp_ready,
  input  logic [7:0]       rsp_data,
  input  logic             rsp_last,
  input  logic             sms_set
);
  logic       wr_ctrl, wr_data, rd_data;
  logic [7:0] ctrl_byte, rsp_byte;
  logic       bmc_busy, rsp_done, rsp_has;

  assign wr_ctrl = host_wr && host_addr == OFS_CTRL;
  assign wr_data = host_wr && host_addr == OFS_DATA;
  assign rd_data = host_rd && host_addr == OFS_DATA;

  bt_mbox_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_ctrl), .wdata(host_wdata),
    .sms_set(sms_set), .rsp_done(rsp_done), .ctrl_byte(ctrl_byte),
    .bmc_busy(bmc_busy), .req_go(req_go)
  );

  bt_mbox_req #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_req (
    .clk(clk), .rst_n(rst_n), .push(wr_data), .din(host_wdata),
    .clr(wr_ctrl && host_wdata[CB_CLR_REQ]), .rd_idx(req_idx),
    .rd_byte(req_byte), .len(req_len)
  );

  bt_mbox_rsp #(.DEPTH(DEPTH)) u_rsp (
    .clk(clk), .rst_n(rst_n), .in_valid(rsp_valid), .in_ready(rsp_ready),
    .in_data(rsp_data), .in_last(rsp_last), .pop(rd_data),
    .rewind(wr_ctrl && host_wdata[CB_CLR_RSP]), .rd_byte(rsp_byte),
    .has_data(rsp_has), .done(rsp_done)
  );

  assign rsp_ready = bmc_busy;

  always_comb begin
    case (host_addr)
      OFS_CTRL: host_rdata = ctrl_byte;
      OFS_DATA: host_rdata = rsp_byte;
      default:  host_rdata = IDLE_BYTE;
    endcase
  end

  a_r8_empty_reads_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr == OFS_DATA && !rsp_has) |-> (host_rdata == 8'hFF));
  a_r9_busy_clears_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && !(wr_ctrl && host_wdata[CB_HOST_GO])) |=> !rsp_ready);
endmodule

// File: tb/test_bt_mbox_regs.sv
module test_bt_mbox_regs;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int LEN_W = 5;
  localparam int IDX_W = $clog2(DEPTH);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] host_addr = '0;
  logic host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_wdata = '0, host_rdata;
  logic req_go;
  logic [LEN_W-1:0] req_len;
  logic [IDX_W-1:0] req_idx = '0;
  logic [7:0] req_byte;
  logic rsp_valid = 1'b0, rsp_ready, rsp_last = 1'b0, sms_set = 1'b0;
  logic [7:0] rsp_data = '0;

  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bt_mbox_regs #(.DEPTH(DEPTH), .LEN_W(LEN_W)) i_bt_mbox_regs (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .req_go(req_go), .req_len(req_len), .req_idx(req_idx), .req_byte(req_byte),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_last(rsp_last), .sms_set(sms_set)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(posedge clk); #1;
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    #1 d = host_rdata;
    @(posedge clk); #1;
    host_rd = 1'b0;
  endtask

  task automatic push(input logic [7:0] d, input logic last);
    @(negedge clk);
    rsp_valid = 1'b1; rsp_data = d; rsp_last = last;
    @(posedge clk); #1;
    rsp_valid = 1'b0; rsp_last = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state, R2 unused offsets
    rd(2'd0, v); chk("R1 ctrl after reset", v, 8'h00);
    chk("R1 req_len after reset", req_len, 0);
    rd(2'd1, v); chk("R1 R8 empty response", v, 8'hFF);
    rd(2'd2, v); chk("R2 offset 2", v, 8'hFF);
    rd(2'd3, v); chk("R2 offset 3", v, 8'hFF);
    chk("R9 ready idle", rsp_ready, 0);

    // R7 R11 R3 request fill sweep
    for (int n = 0; n <= 12; n++) begin
      wr(2'd0, 8'h01);
      chk("R3 clear req", req_len, 0);
      for (int k = 0; k < n; k++) wr(2'd1, 8'(k * 7 + n));
      chk("R7 req_len", req_len, n);
      for (int k = 0; k < (n < DEPTH ? n : DEPTH); k++) begin
        req_idx = IDX_W'(k); #1;
        chk("R11 req_byte", req_byte, (k * 7 + n) & 8'hFF);
      end
    end
    wr(2'd0, 8'h01);
    for (int k = 0; k < 40; k++) wr(2'd1, 8'(k));
    chk("R7 saturate", req_len, 31);
    wr(2'd0, 8'h01);
    chk("R3 clear after saturate", req_len, 0);

    // R5 host-busy toggle
    wr(2'd0, 8'h40); rd(2'd0, v); chk("R5 toggle on", v, 8'h40);
    wr(2'd0, 8'h00); rd(2'd0, v); chk("R5 zero no effect", v, 8'h40);
    wr(2'd0, 8'h40); rd(2'd0, v); chk("R5 toggle off", v, 8'h00);

    // R6 R8 R9 R3 R4 response sweep
    for (int L = 1; L <= 10; L++) begin
      int stored;
      stored = (L < DEPTH) ? L : DEPTH;
      chk("R9 ready before request", rsp_ready, 0);
      wr(2'd0, 8'h04);
      chk("R6 req_go pulse", req_go, 1);
      @(posedge clk); #1;
      chk("R6 req_go single cycle", req_go, 0);
      rd(2'd0, v); chk("R6 busy set", v, 8'h80);
      chk("R9 ready while busy", rsp_ready, 1);
      for (int i = 0; i < L; i++) push(8'(8'h30 + i + L), i == L - 1);
      chk("R9 ready after last", rsp_ready, 0);
      rd(2'd0, v); chk("R9 attention after last", v, 8'h08);
      if (L >= 3) begin
        rd(2'd1, v); chk("R8 first byte", v, 8'h30 + L);
        rd(2'd1, v); chk("R8 second byte", v, 8'h31 + L);
        wr(2'd0, 8'h02);
      end
      for (int i = 0; i < stored; i++) begin
        rd(2'd1, v); chk("R8 R3 response byte", v, (8'h30 + i + L) & 8'hFF);
      end
      rd(2'd1, v); chk("R8 drained", v, 8'hFF);
      wr(2'd0, 8'h00); rd(2'd0, v); chk("R4 zero keeps attention", v, 8'h08);
      wr(2'd0, 8'h08); rd(2'd0, v); chk("R4 clear attention", v, 8'h00);
    end

    // R10 system-management attention
    @(negedge clk); sms_set = 1'b1; @(posedge clk); #1 sms_set = 1'b0;
    rd(2'd0, v); chk("R10 sms set", v, 8'h10);
    wr(2'd0, 8'h10); rd(2'd0, v); chk("R4 sms clear", v, 8'h00);
    @(negedge clk);
    sms_set = 1'b1; host_addr = 2'd0; host_wdata = 8'h10; host_wr = 1'b1;
    @(posedge clk); #1 sms_set = 1'b0; host_wr = 1'b0;
    rd(2'd0, v); chk("R10 set beats clear", v, 8'h10);
    wr(2'd0, 8'h10);

    // R10 response attention set beats clear
    wr(2'd0, 8'h04);
    @(negedge clk);
    rsp_valid = 1'b1; rsp_data = 8'h5A; rsp_last = 1'b1;
    host_addr = 2'd0; host_wdata = 8'h08; host_wr = 1'b1;
    @(posedge clk); #1 rsp_valid = 1'b0; rsp_last = 1'b0; host_wr = 1'b0;
    rd(2'd0, v); chk("R10 rsp attention set beats clear", v, 8'h08);
    rd(2'd1, v); chk("R8 single byte", v, 8'h5A);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule